// File: doc/BRIEF.md
# RGB Parallel Panel Timing Generator

This block produces the raster timing for a parallel RGB panel. From a source clock it makes a pixel strobe by integer division. It then walks a horizontal and a vertical counter through four phases each: sync pulse, back porch, active region and front porch. The outputs are horizontal sync, vertical sync, data-enable, a pixel clock strobe and the pixel coordinates inside the active region. Each phase length is written as its length minus one. The divider field is written as the divide ratio minus one. The largest ratio the divider applies is 255.

Each output sync, the data-enable and the pixel clock strobe has its own invert bit, so panels of either polarity can be driven. A one-cycle interrupt pulse marks entry into one chosen vertical phase. Entry into the vertical front porch is the usual choice for starting the next frame's update. Scanning starts only when both the video enable and the per-frame enable are high. Both enables are sampled again at every frame boundary. If either is low there, the raster stops after the last pixel of the frame and the outputs rest at their inactive levels. Timing fields are captured at each frame start, so reprogramming during a frame never gives a torn frame.

Top module: `rgb_vtg`

## Requirements
- R1: A line is made of (h_sync_m1+1) sync pixels, then (h_back_m1+1) back porch pixels, then (h_act_m1+1) active pixels, then (h_front_m1+1) front porch pixels. The horizontal sync is active exactly during the sync pixels.
- R2: The vertical counter advances once per completed line and passes through sync, back porch, active and front porch with lengths of (field+1) lines. The vertical sync is active for all pixels of the sync lines, and every vertical phase change lands on the first pixel of a line.
- R3: The pixel strobe pix_ce_o is high for one source clock every (div_m1+1) clocks. Any div_m1 above 254 is treated as 254, giving a ratio of 255. Each strobe advances the raster by one pixel.
- R4: de is high only where both counters are in their active phases. x_o is the pixel index inside the horizontal active phase and is 0 outside it. y_o is the line index inside the vertical active phase and is 0 outside it.
- R5: Invert bits, where 1 inverts, act separately on hsync_o, vsync_o, de_o and pclk_o. The uninverted sync and data-enable levels are active-high. pclk_o is the pixel strobe XOR its invert bit.
- R6: irq_o is a one-clock pulse in the clock where the vertical phase first equals irq_sel. This includes the first line of a started raster when irq_sel is 0. The encoding is 0 sync, 1 back porch, 2 active, 3 front porch.
- R7: While idle, the raster starts on the first pixel strobe at which video_en and frame_en are both 1. The first pixel, a sync pixel at line 0, is presented in the clock after that strobe.
- R8: At the strobe that ends the last pixel of a frame, the raster continues only if video_en and frame_en are both 1. Otherwise it stops. While stopped, the uninverted syncs and data-enable are low, and x_o and y_o are 0.
- R9: All eight timing fields are captured when a frame starts. Changing them during a frame affects only the following frame.
- R10: After reset the block is idle, with all outputs at their inactive levels and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Global video enable |
| frame_en | input | 1 | Per-frame enable, sampled at frame boundaries |
| div_m1 | input | DIVW | Pixel clock divide ratio minus one |
| h_sync_m1 | input | HW | Horizontal sync width minus one |
| h_back_m1 | input | HW | Horizontal back porch minus one |
| h_act_m1 | input | HW | Active pixels per line minus one |
| h_front_m1 | input | HW | Horizontal front porch minus one |
| v_sync_m1 | input | VW | Vertical sync lines minus one |
| v_back_m1 | input | VW | Vertical back porch lines minus one |
| v_act_m1 | input | VW | Active lines minus one |
| v_front_m1 | input | VW | Vertical front porch lines minus one |
| inv_hsync | input | 1 | Invert horizontal sync |
| inv_vsync | input | 1 | Invert vertical sync |
| inv_de | input | 1 | Invert data-enable |
| inv_pclk | input | 1 | Invert pixel clock strobe |
| irq_sel | input | 2 | Vertical phase that raises the interrupt |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pclk_o | output | 1 | Pixel clock strobe after polarity |
| pix_ce_o | output | 1 | Uninverted pixel strobe |
| x_o | output | HW | Horizontal active index |
| y_o | output | VW | Vertical active index |
| irq_o | output | 1 | Frame phase interrupt pulse |

## Verification
Small directed rasters with every field at zero expose off-by-one errors in the minus-one encoding. Tiny phases with a divide ratio of one place sync and active edges on back-to-back strobes. Random configurations of mixed phase lengths, ratios, polarities and interrupt phases show whether each phase boundary and the polarity logic land on the right pixel. A maximum divider field separates correct clamping from wraparound. Directed sequences that drop an enable or rewrite fields during a frame show whether the stop waits for the frame end and whether the new timing waits for the next frame.

// File: rtl/rgb_vtg_pkg.sv
package rgb_vtg_pkg;

   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACTV  = 2'd2,
      PH_FRONT = 2'd3
   } vtg_phase_e;

   function automatic vtg_phase_e vtg_next_phase(input vtg_phase_e ph);
      case (ph)
         PH_SYNC:  return PH_BACK;
         PH_BACK:  return PH_ACTV;
         PH_ACTV:  return PH_FRONT;
         default:  return PH_SYNC;
      endcase
   endfunction

endpackage

// File: rtl/vtg_pixdiv.sv
module vtg_pixdiv #(
   parameter int DIVW      = 8,
   parameter int RATIO_MAX = 255
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIVW-1:0] div_m1,
   output logic            ce_o
);
   localparam logic [DIVW-1:0] LIM_CAP = DIVW'(RATIO_MAX - 1);

   generate
      if (DIVW < 1 || RATIO_MAX < 1 || RATIO_MAX > (1 << DIVW)) begin : g_bad_cfg
         $error("vtg_pixdiv: RATIO_MAX must lie in 1 .. 2**DIVW");
      end
   endgenerate

   logic [DIVW-1:0] lim;
   logic [DIVW-1:0] cnt_q;

   // the cap is only built when the field can exceed it
   generate
      if (RATIO_MAX == (1 << DIVW)) begin : g_no_cap
         assign lim = div_m1;
      end else begin : g_cap
         assign lim = (div_m1 > LIM_CAP) ? LIM_CAP : div_m1;
      end
   endgenerate

   assign ce_o = (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (ce_o) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   // R3: a ratio above one never gives strobes on adjacent clocks
   a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_o && lim != '0) |=> (!ce_o || lim == '0));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
   import rgb_vtg_pkg::*;
#(
   parameter int W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic [W-1:0] sync_m1,
   input  logic [W-1:0] back_m1,
   input  logic [W-1:0] act_m1,
   input  logic [W-1:0] front_m1,
   output vtg_phase_e phase_o,
   output logic [W-1:0] cnt_o,
   output logic       last_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("vtg_axis: W must be at least 2");
      end
   endgenerate

   vtg_phase_e   ph_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] len_m1;

   always_comb begin
      case (ph_q)
         PH_SYNC: len_m1 = sync_m1;
         PH_BACK: len_m1 = back_m1;
         PH_ACTV: len_m1 = act_m1;
         default: len_m1 = front_m1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_SYNC;
         cnt_q <= '0;
      end else if (step) begin
         if (cnt_q >= len_m1) begin
            cnt_q <= '0;
            ph_q  <= vtg_next_phase(ph_q);
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign phase_o = ph_q;
   assign cnt_o   = cnt_q;
   assign last_o  = (ph_q == PH_FRONT) && (cnt_q >= len_m1);

   // R1: phases are only ever left for their successor
   a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != $past(ph_q)) |-> (ph_q == vtg_next_phase($past(ph_q))));

   // R1: a phase change always starts its count at zero
   a_r1_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != $past(ph_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/vtg_polarity.sv
module vtg_polarity #(
   parameter int N = 4
) (
   input  logic [N-1:0] raw_i,
   input  logic [N-1:0] inv_i,
   output logic [N-1:0] out_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign out_o[i] = raw_i[i] ^ inv_i[i];
      end
   endgenerate
endmodule

// File: rtl/rgb_vtg.sv
module rgb_vtg
   import rgb_vtg_pkg::*;
#(
   parameter int HW        = 12,
   parameter int VW        = 12,
   parameter int DIVW      = 8,
   parameter int RATIO_MAX = 255
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            video_en,
   input  logic            frame_en,
   input  logic [DIVW-1:0] div_m1,
   input  logic [HW-1:0]   h_sync_m1,
   input  logic [HW-1:0]   h_back_m1,
   input  logic [HW-1:0]   h_act_m1,
   input  logic [HW-1:0]   h_front_m1,
   input  logic [VW-1:0]   v_sync_m1,
   input  logic [VW-1:0]   v_back_m1,
   input  logic [VW-1:0]   v_act_m1,
   input  logic [VW-1:0]   v_front_m1,
   input  logic            inv_hsync,
   input  logic            inv_vsync,
   input  logic            inv_de,
   input  logic            inv_pclk,
   input  logic [1:0]      irq_sel,
   output logic            hsync_o,
   output logic            vsync_o,
   output logic            de_o,
   output logic            pclk_o,
   output logic            pix_ce_o,
   output logic [HW-1:0]   x_o,
   output logic [VW-1:0]   y_o,
   output logic            irq_o
);
   localparam int NPOL = 4;

   generate
      if (HW < 2 || VW < 2) begin : g_bad_dims
         $error("rgb_vtg: HW and VW must be at least 2");
      end
   endgenerate

   logic ce;
   logic go;
   logic run_q, run_d_q;
   logic h_step, v_step, frame_end;
   logic h_last, v_last;
   vtg_phase_e h_ph, v_ph, v_ph_d_q;
   logic [HW-1:0] h_cnt;
   logic [VW-1:0] v_cnt;

   logic [HW-1:0] sh_h_sync, sh_h_back, sh_h_act, sh_h_front;
   logic [VW-1:0] sh_v_sync, sh_v_back, sh_v_act, sh_v_front;

   vtg_pixdiv #(.DIVW(DIVW), .RATIO_MAX(RATIO_MAX)) u_div (
      .clk(clk), .rst_n(rst_n), .div_m1(div_m1), .ce_o(ce));

   assign go        = video_en & frame_en;
   assign h_step    = ce & run_q;
   assign v_step    = h_step & h_last;
   assign frame_end = run_q & h_last & v_last;

   vtg_axis #(.W(HW)) u_hax (
      .clk(clk), .rst_n(rst_n), .step(h_step),
      .sync_m1(sh_h_sync), .back_m1(sh_h_back), .act_m1(sh_h_act), .front_m1(sh_h_front),
      .phase_o(h_ph), .cnt_o(h_cnt), .last_o(h_last));

   vtg_axis #(.W(VW)) u_vax (
      .clk(clk), .rst_n(rst_n), .step(v_step),
      .sync_m1(sh_v_sync), .back_m1(sh_v_back), .act_m1(sh_v_act), .front_m1(sh_v_front),
      .phase_o(v_ph), .cnt_o(v_cnt), .last_o(v_last));

   // run control and per-frame capture of timing fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         sh_h_sync  <= '0; sh_h_back <= '0; sh_h_act <= '0; sh_h_front <= '0;
         sh_v_sync  <= '0; sh_v_back <= '0; sh_v_act <= '0; sh_v_front <= '0;
      end else if (ce && ((!run_q && go) || frame_end)) begin
         if (go) begin
            run_q      <= 1'b1;
            sh_h_sync  <= h_sync_m1; sh_h_back <= h_back_m1;
            sh_h_act   <= h_act_m1;  sh_h_front <= h_front_m1;
            sh_v_sync  <= v_sync_m1; sh_v_back <= v_back_m1;
            sh_v_act   <= v_act_m1;  sh_v_front <= v_front_m1;
         end else begin
            run_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_d_q  <= 1'b0;
         v_ph_d_q <= PH_SYNC;
      end else begin
         run_d_q  <= run_q;
         v_ph_d_q <= v_ph;
      end
   end

   logic hs_raw, vs_raw, de_raw;
   assign hs_raw = run_q && (h_ph == PH_SYNC);
   assign vs_raw = run_q && (v_ph == PH_SYNC);
   assign de_raw = run_q && (h_ph == PH_ACTV) && (v_ph == PH_ACTV);

   assign x_o = (h_ph == PH_ACTV) ? h_cnt : '0;
   assign y_o = (v_ph == PH_ACTV) ? v_cnt : '0;

   assign irq_o = run_q && (v_ph == vtg_phase_e'(irq_sel)) &&
                  ((v_ph != v_ph_d_q) || !run_d_q);

   logic [NPOL-1:0] pol_raw, pol_inv, pol_out;
   assign pol_raw = {ce, de_raw, vs_raw, hs_raw};
   assign pol_inv = {inv_pclk, inv_de, inv_vsync, inv_hsync};

   vtg_polarity #(.N(NPOL)) u_pol (.raw_i(pol_raw), .inv_i(pol_inv), .out_o(pol_out));

   assign hsync_o  = pol_out[0];
   assign vsync_o  = pol_out[1];
   assign de_o     = pol_out[2];
   assign pclk_o   = pol_out[3];
   assign pix_ce_o = ce;

   // R8: the raster only stops with both counters back at the frame origin
   a_r8_stop_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> (h_ph == PH_SYNC && v_ph == PH_SYNC && h_cnt == '0 && v_cnt == '0));

   // R2: vertical phase changes land on the first pixel of a line
   a_r2_vphase_line_start: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(v_ph) |-> (h_ph == PH_SYNC && h_cnt == '0));

   // R6: the interrupt is a single-clock pulse
   a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R4: coordinates stay inside the captured active size while data is enabled
   a_r4_coord_bound: assert property (@(posedge clk) disable iff (!rst_n)
      de_raw |-> (x_o <= sh_h_act && y_o <= sh_v_act));

endmodule

// File: tb/tb_rgb_vtg.sv
`timescale 1ns/1ps
module tb_rgb_vtg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic video_en = 0, frame_en = 0;
   logic [7:0]  div_m1 = 0;
   logic [11:0] h_sync_m1 = 0, h_back_m1 = 0, h_act_m1 = 0, h_front_m1 = 0;
   logic [11:0] v_sync_m1 = 0, v_back_m1 = 0, v_act_m1 = 0, v_front_m1 = 0;
   logic inv_hsync = 0, inv_vsync = 0, inv_de = 0, inv_pclk = 0;
   logic [1:0] irq_sel = 2'd3;
   logic hsync_o, vsync_o, de_o, pclk_o, pix_ce_o, irq_o;
   logic [11:0] x_o, y_o;

   rgb_vtg dut (
      .clk(clk), .rst_n(rst_n), .video_en(video_en), .frame_en(frame_en), .div_m1(div_m1),
      .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
      .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
      .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_de(inv_de), .inv_pclk(inv_pclk),
      .irq_sel(irq_sel), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_o(pclk_o),
      .pix_ce_o(pix_ce_o), .x_o(x_o), .y_o(y_o), .irq_o(irq_o));

   int tests = 0, fails = 0;
   string cur_tag = "R10";
   bit checking = 0;

   // ---------------- reference model (index based) ----------------
   int m_div, m_hx, m_vy, m_vph_d;
   bit m_run, m_run_d;
   int s_hs, s_hb, s_ha, s_hf, s_vs, s_vb, s_va, s_vf;

   function automatic int f_lim(int d);
      return (d > 254) ? 254 : d;
   endfunction

   function automatic int f_vph(int y);
      if (y < s_vs + 1) return 0;
      if (y < s_vs + s_vb + 2) return 1;
      if (y < s_vs + s_vb + s_va + 3) return 2;
      return 3;
   endfunction

   function automatic bit f_hact(int x);
      return (x >= s_hs + s_hb + 2) && (x < s_hs + s_hb + s_ha + 3);
   endfunction

   function automatic bit f_vact(int y);
      return (y >= s_vs + s_vb + 2) && (y < s_vs + s_vb + s_va + 3);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_div = 0; m_hx = 0; m_vy = 0; m_vph_d = 0; m_run = 0; m_run_d = 0;
         s_hs = 0; s_hb = 0; s_ha = 0; s_hf = 0; s_vs = 0; s_vb = 0; s_va = 0; s_vf = 0;
      end else begin
         bit ce, go;
         int htot, vtot;
         ce = (m_div >= f_lim(int'(div_m1)));
         go = video_en && frame_en;
         m_vph_d = f_vph(m_vy);
         m_run_d = m_run;
         m_div = ce ? 0 : m_div + 1;
         if (ce) begin
            htot = s_hs + s_hb + s_ha + s_hf + 4;
            vtot = s_vs + s_vb + s_va + s_vf + 4;
            if (!m_run) begin
               if (go) begin
                  m_run = 1; m_hx = 0; m_vy = 0;
                  s_hs = int'(h_sync_m1); s_hb = int'(h_back_m1); s_ha = int'(h_act_m1); s_hf = int'(h_front_m1);
                  s_vs = int'(v_sync_m1); s_vb = int'(v_back_m1); s_va = int'(v_act_m1); s_vf = int'(v_front_m1);
               end
            end else if (m_hx == htot - 1) begin
               m_hx = 0;
               if (m_vy == vtot - 1) begin
                  m_vy = 0;
                  if (go) begin
                     s_hs = int'(h_sync_m1); s_hb = int'(h_back_m1); s_ha = int'(h_act_m1); s_hf = int'(h_front_m1);
                     s_vs = int'(v_sync_m1); s_vb = int'(v_back_m1); s_va = int'(v_act_m1); s_vf = int'(v_front_m1);
                  end else begin
                     m_run = 0;
                  end
               end else begin
                  m_vy = m_vy + 1;
               end
            end else begin
               m_hx = m_hx + 1;
            end
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         if (fails <= 30)
            $display("FAIL %s (%s) %s: actual %0d expected %0d at %0t", req, cur_tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && checking) begin
         bit ce_e, ha, va;
         int xe, ye, irq_e;
         ce_e = (m_div >= f_lim(int'(div_m1)));
         ha = m_run && f_hact(m_hx);
         va = m_run && f_vact(m_vy);
         xe = ha ? m_hx - (s_hs + s_hb + 2) : 0;
         ye = va ? m_vy - (s_vs + s_vb + 2) : 0;
         irq_e = (m_run && f_vph(m_vy) == int'(irq_sel) && (f_vph(m_vy) != m_vph_d || !m_run_d)) ? 1 : 0;
         chk("R1", "hsync", int'(hsync_o), int'((m_run && m_hx < s_hs + 1) ^ inv_hsync));
         chk("R2", "vsync", int'(vsync_o), int'((m_run && m_vy < s_vs + 1) ^ inv_vsync));
         chk("R4", "de", int'(de_o), int'((ha && va) ^ inv_de));
         chk("R4", "x", int'(x_o), xe);
         chk("R4", "y", int'(y_o), ye);
         chk("R3", "pix_ce", int'(pix_ce_o), int'(ce_e));
         chk("R5", "pclk", int'(pclk_o), int'(ce_e ^ inv_pclk));
         chk("R6", "irq", int'(irq_o), irq_e);
      end
   end

   // ---------------- helpers ----------------
   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++; tests++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         report();
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic int frame_cycles();
      int ht, vt;
      ht = int'(h_sync_m1) + int'(h_back_m1) + int'(h_act_m1) + int'(h_front_m1) + 4;
      vt = int'(v_sync_m1) + int'(v_back_m1) + int'(v_act_m1) + int'(v_front_m1) + 4;
      return ht * vt * (f_lim(int'(div_m1)) + 1);
   endfunction

   task automatic set_timing(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf);
      h_sync_m1 = 12'(hs); h_back_m1 = 12'(hb); h_act_m1 = 12'(ha); h_front_m1 = 12'(hf);
      v_sync_m1 = 12'(vs); v_back_m1 = 12'(vb); v_act_m1 = 12'(va); v_front_m1 = 12'(vf);
   endtask

   task automatic stop_and_wait(int maxc);
      frame_en = 0;
      tick(maxc + 600);
   endtask

   initial begin
      int gap, seen;
      void'($urandom(32'h5EED_0017));
      set_timing(1, 1, 3, 0, 0, 1, 2, 1);
      tick(3);
      rst_n = 1;
      @(negedge clk);
      // R10: idle after reset
      chk("R10", "hsync idle", int'(hsync_o), 0);
      chk("R10", "vsync idle", int'(vsync_o), 0);
      chk("R10", "de idle", int'(de_o), 0);
      chk("R10", "irq idle", int'(irq_o), 0);
      checking = 1;
      tick(5);

      // R7: video enable alone does not start scanning
      cur_tag = "R7";
      video_en = 1;
      tick(40);
      @(negedge clk);
      chk("R7", "hsync before frame enable", int'(hsync_o), 0);
      chk("R7", "vsync before frame enable", int'(vsync_o), 0);
      tick(1);
      frame_en = 1;
      tick(2 * frame_cycles() + 7);

      // R5: all polarities inverted, interrupt on back porch
      cur_tag = "R5";
      inv_hsync = 1; inv_vsync = 1; inv_de = 1; inv_pclk = 1; irq_sel = 2'd1;
      div_m1 = 8'd2;
      tick(frame_cycles() + 11);
      inv_hsync = 0; inv_de = 0; irq_sel = 2'd3;

      // R9: rewrite fields mid-frame
      cur_tag = "R9";
      tick(frame_cycles() / 2);
      set_timing(0, 2, 5, 1, 1, 0, 3, 0);
      tick(3 * frame_cycles());

      // R8: drop the per-frame enable mid-frame
      cur_tag = "R8";
      tick(frame_cycles() / 3);
      frame_en = 0;
      tick(frame_cycles() + 20);
      @(negedge clk);
      chk("R8", "vsync after stop", int'(vsync_o), int'(inv_vsync));
      chk("R8", "hsync after stop", int'(hsync_o), int'(inv_hsync));
      chk("R8", "x after stop", int'(x_o), 0);
      tick(1);

      // R3: divider field above the cap
      cur_tag = "R3";
      inv_vsync = 0; inv_pclk = 0;
      div_m1 = 8'd255;
      set_timing(0, 0, 0, 0, 0, 0, 0, 0);
      irq_sel = 2'd0;
      frame_en = 1;
      gap = 0; seen = 0;
      while (seen < 3) begin
         @(negedge clk);
         if (pix_ce_o) begin
            if (seen > 0) chk("R3", "strobe spacing", gap, 255);
            seen++;
            gap = 1;
         end else gap++;
      end
      tick(frame_cycles() + 5);
      stop_and_wait(frame_cycles());

      // random configurations with directed zero-length corners mixed in
      for (int it = 0; it < 8; it++) begin
         cur_tag = "RND";
         if (it == 0) set_timing(0, 0, 0, 0, 0, 0, 0, 0);
         else set_timing($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 4), $urandom_range(0, 3),
                         $urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 3), $urandom_range(0, 2));
         div_m1 = (it == 0) ? 8'd0 : 8'($urandom_range(0, 3));
         irq_sel = 2'($urandom_range(0, 3));
         inv_hsync = 1'($urandom); inv_vsync = 1'($urandom);
         inv_de = 1'($urandom); inv_pclk = 1'($urandom);
         video_en = 1; frame_en = 1;
         tick(2 * frame_cycles() + $urandom_range(0, 50));
         if (it % 3 == 1) begin
            video_en = 0;
            tick(frame_cycles() + 10);
         end
         stop_and_wait(frame_cycles());
      end

      checking = 0;
      report();
      $finish;
   end
endmodule